// File: doc/BRIEF.md
# Message Buffer Interrupt Flag and Mask Bank

This block holds one pending-event flag and one enable bit for each of 64 message buffers. The flags and enables are grouped into 32-bit registers on a simple register bus. The controller core raises a one-cycle completion pulse for a buffer when a transmission or reception on it succeeds. That pulse sets the buffer's flag. Software reads the flag registers to find out which buffers need service. It then acknowledges them by writing ones to the flag bits.

A single interrupt request line is raised while any buffer has both its flag and its enable bit set. Writing an enable bit therefore raises or drops the request without any change to the flags. A second output gives one bit per buffer. It tells the buffer-storage logic to refuse CPU writes into a transmit buffer while that buffer's flag is pending and abort mode is on.

Bus accesses are sequenced by a two-state machine. BUS_IDLE moves to BUS_RDATA when a read request arrives. BUS_RDATA stays in BUS_RDATA on a back-to-back read and returns to BUS_IDLE on any other cycle. Writes take effect in whichever state they arrive.

Top module: `mb_irq_bank`

## Requirements
- R1: After reset, every flag and every enable bit is 0, and `irq`, `wr_block`, `bus_rvalid` and `bus_rdata` are all 0.
- R2: A 1 on `done_pulse[i]` at a clock edge sets flag i. Register address 0 shows flags of buffers 0..31, with data bit k holding buffer k. Address 1 shows buffers 32..63, with data bit k holding buffer 32+k.
- R3: A write to address 0 or 1 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If a completion pulse and a write-one clear hit the same flag at the same edge, the flag ends up set.
- R5: Address 2 holds the enable bits of buffers 0..31 and address 3 those of buffers 32..63, with the same bit mapping as the flags. These registers are fully writable and read back exactly what was written.
- R6: `irq` is a register. At each edge it loads the OR over all buffers of (flag AND enable), as held before that edge. A write that sets or clears an enable bit of a pending buffer therefore moves `irq` one cycle after the register changes.
- R7: `wr_block[i]` is 1 exactly when `abort_en` is 1, `buf_is_tx[i]` is 1 (transmit) and flag i is set. It follows these inputs and the flag register without further delay.
- R8: A read request (`bus_valid`=1, `bus_write`=0) at an edge makes `bus_rvalid` 1 for the following cycle. In that cycle `bus_rdata` carries the addressed register as it was before the edge. `bus_rdata` is 0 whenever `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0/1 flags low/high, 2/3 enables low/high |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| done_pulse | input | 64 | Per-buffer completion pulse |
| buf_is_tx | input | 64 | Per-buffer direction, 1 = transmit |
| abort_en | input | 1 | Abort mode enable |
| irq | output | 1 | Interrupt request |
| wr_block | output | 64 | Per-buffer CPU write lockout |

## Verification
The bound checker watches several properties on every cycle. It checks that completion pulses always leave their flags set, that no flag rises without a pulse, and that the request line always equals the previous cycle's flag-and-enable product. It also checks that the write lockout never appears without abort mode or on a receive buffer, and that read data is zero outside a response. The bench's scenarios are needed for the rest: that a write-one clear hits exactly the addressed bits and spares zero bits, the bit-to-buffer mapping across both register halves, and enable readback. They also show the request line following an enable write while flags stay pending, and back-to-back reads holding BUS_RDATA.

// File: rtl/mbirq_pkg.sv
package mbirq_pkg;

    localparam int MBI_NUM_BUF = 64;
    localparam int MBI_REG_W   = 32;

    typedef enum logic {
        BUS_IDLE  = 1'b0,
        BUS_RDATA = 1'b1
    } bus_state_e;

endpackage

// File: rtl/mbirq_flag_word.sv
module mbirq_flag_word #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] done,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] flag_q,
    output logic [REG_W-1:0] mask_q,
    output logic             any_irq
);

    logic [REG_W-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_we ? wdata : '0;
    end

    // set term is ORed last so a pulse beats a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_bits) | done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

    always_comb begin
        any_irq = |(flag_q & mask_q);
    end

endmodule

// File: rtl/mbirq_bus_fsm.sv
module mbirq_bus_fsm
    import mbirq_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [NUM_WORDS*REG_W-1:0] flag_flat,
    input  logic [NUM_WORDS*REG_W-1:0] mask_flat,
    output logic [NUM_WORDS-1:0]       flag_we,
    output logic [NUM_WORDS-1:0]       mask_we,
    output logic                       rvalid,
    output logic [REG_W-1:0]           rdata
);

    localparam int WIDX_W = ADDR_W - 1;

    bus_state_e        state_q, state_d;
    logic              rd_req, wr_req, sel_mask;
    logic [WIDX_W-1:0] sel_word;
    logic [REG_W-1:0]  rd_word;
    logic [REG_W-1:0]  rdata_q;

    always_comb begin
        rd_req   = bus_valid & ~bus_write;
        wr_req   = bus_valid &  bus_write;
        sel_mask = bus_addr[ADDR_W-1];
        sel_word = bus_addr[WIDX_W-1:0];
        rd_word  = sel_mask ? mask_flat[sel_word*REG_W +: REG_W]
                            : flag_flat[sel_word*REG_W +: REG_W];
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_strobe
        always_comb begin
            flag_we[w] = wr_req & ~sel_mask & (sel_word == WIDX_W'(w));
            mask_we[w] = wr_req &  sel_mask & (sel_word == WIDX_W'(w));
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (rd_req) state_d = BUS_RDATA;
            BUS_RDATA: state_d = rd_req ? BUS_RDATA : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_req ? rd_word : '0;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            BUS_IDLE:  ;
            BUS_RDATA: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/mb_irq_bank.sv
module mb_irq_bank
    import mbirq_pkg::*;
#(
    parameter int NUM_BUF = MBI_NUM_BUF,
    parameter int REG_W   = MBI_REG_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_valid,
    input  logic                                 bus_write,
    input  logic [$clog2(NUM_BUF/REG_W):0]       bus_addr,
    input  logic [REG_W-1:0]                     bus_wdata,
    output logic                                 bus_rvalid,
    output logic [REG_W-1:0]                     bus_rdata,
    input  logic [NUM_BUF-1:0]                   done_pulse,
    input  logic [NUM_BUF-1:0]                   buf_is_tx,
    input  logic                                 abort_en,
    output logic                                 irq,
    output logic [NUM_BUF-1:0]                   wr_block
);

    localparam int NUM_WORDS = NUM_BUF / REG_W;
    localparam int ADDR_W    = $clog2(NUM_WORDS) + 1;

    logic [NUM_BUF-1:0]   flag_all;
    logic [NUM_BUF-1:0]   mask_all;
    logic [NUM_WORDS-1:0] word_irq;
    logic [NUM_WORDS-1:0] flag_we;
    logic [NUM_WORDS-1:0] mask_we;
    logic                 irq_q;

    mbirq_bus_fsm #(
        .REG_W     (REG_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .flag_flat (flag_all),
        .mask_flat (mask_all),
        .flag_we   (flag_we),
        .mask_we   (mask_we),
        .rvalid    (bus_rvalid),
        .rdata     (bus_rdata)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        mbirq_flag_word #(
            .REG_W (REG_W)
        ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .done    (done_pulse[w*REG_W +: REG_W]),
            .clr_we  (flag_we[w]),
            .mask_we (mask_we[w]),
            .wdata   (bus_wdata),
            .flag_q  (flag_all[w*REG_W +: REG_W]),
            .mask_q  (mask_all[w*REG_W +: REG_W]),
            .any_irq (word_irq[w])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |word_irq;
        end
    end

    always_comb begin
        irq      = irq_q;
        wr_block = {NUM_BUF{abort_en}} & buf_is_tx & flag_all;
    end

endmodule

// File: rtl/mb_irq_bank_chk.sv
module mb_irq_bank_chk #(
    parameter int NUM_BUF = 64,
    parameter int REG_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] done_pulse,
    input logic [NUM_BUF-1:0] buf_is_tx,
    input logic               abort_en,
    input logic [NUM_BUF-1:0] flag_q,
    input logic [NUM_BUF-1:0] mask_q,
    input logic               irq,
    input logic [NUM_BUF-1:0] wr_block,
    input logic               bus_valid,
    input logic               bus_write,
    input logic               bus_rvalid,
    input logic [REG_W-1:0]   bus_rdata
);

    // R2 R4
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse != '0) |=> ((flag_q & $past(done_pulse)) == $past(done_pulse)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(flag_q & mask_q)));

    // R7
    block_needs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_en |-> (wr_block == '0));

    // R7
    block_tx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_block & ~buf_is_tx) == '0));

    // R8
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R8
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

endmodule

bind mb_irq_bank mb_irq_bank_chk #(
    .NUM_BUF (NUM_BUF),
    .REG_W   (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_pulse (done_pulse),
    .buf_is_tx  (buf_is_tx),
    .abort_en   (abort_en),
    .flag_q     (flag_all),
    .mask_q     (mask_all),
    .irq        (irq),
    .wr_block   (wr_block),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata)
);

// File: tb/mb_irq_bank_tb.sv
module mb_irq_bank_tb;

    localparam int NB = 64;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tb_valid = 1'b0;
    logic          tb_write = 1'b0;
    logic [1:0]    tb_addr = '0;
    logic [RW-1:0] tb_wdata = '0;
    logic [NB-1:0] tb_done = '0;
    logic [NB-1:0] tb_tx = '0;
    logic          tb_abort = 1'b0;
    logic          bus_rvalid, irq;
    logic [RW-1:0] bus_rdata;
    logic [NB-1:0] wr_block;

    bit [NB-1:0] m_flag, m_mask;
    bit          m_irq, m_rv;
    bit [RW-1:0] m_rd;
    int          n_vec = 0, n_bad = 0;
    string       cur_req = "R1";
    bit          done_flag = 0;

    always #4 clk = ~clk;

    mb_irq_bank u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (tb_valid),
        .bus_write  (tb_write),
        .bus_addr   (tb_addr),
        .bus_wdata  (tb_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .done_pulse (tb_done),
        .buf_is_tx  (tb_tx),
        .abort_en   (tb_abort),
        .irq        (irq),
        .wr_block   (wr_block)
    );

    function automatic bit [RW-1:0] model_read(input bit [1:0] a);
        bit [RW-1:0] v;
        for (int k = 0; k < RW; k++) begin
            int b = k + (a[0] ? RW : 0);
            v[k] = a[1] ? m_mask[b] : m_flag[b];
        end
        return v;
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic compare();
        bit [NB-1:0] exp_blk;
        for (int b = 0; b < NB; b++)
            exp_blk[b] = tb_abort && tb_tx[b] && m_flag[b];
        n_vec++;
        if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL %s (R6) irq actual=%0b expected=%0b", cur_req, irq, m_irq);
        end
        if (wr_block !== exp_blk) begin
            n_bad++;
            $display("FAIL %s (R7) wr_block actual=%h expected=%h", cur_req, wr_block, exp_blk);
        end
        if (bus_rvalid !== m_rv) begin
            n_bad++;
            $display("FAIL %s (R8) rvalid actual=%0b expected=%0b", cur_req, bus_rvalid, m_rv);
        end
        if (bus_rdata !== m_rd) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, m_rd);
        end
    endtask

    // one clock: reference model advances at the edge, outputs compared 1 ns later
    task automatic step();
        bit nxt_irq;
        @(posedge clk);
        if (!rst_n) begin
            m_flag = '0; m_mask = '0; m_irq = 0; m_rv = 0; m_rd = '0;
        end else begin
            nxt_irq = 0;
            for (int b = 0; b < NB; b++)
                if (m_flag[b] && m_mask[b]) nxt_irq = 1;
            if (tb_valid && !tb_write) begin
                m_rd = model_read(tb_addr); m_rv = 1;
            end else begin
                m_rd = '0; m_rv = 0;
            end
            if (tb_valid && tb_write) begin
                for (int k = 0; k < RW; k++) begin
                    int b = k + (tb_addr[0] ? RW : 0);
                    if (tb_addr[1]) m_mask[b] = tb_wdata[k];
                    else if (tb_wdata[k]) m_flag[b] = 0;
                end
            end
            for (int b = 0; b < NB; b++)
                if (tb_done[b]) m_flag[b] = 1;
            m_irq = nxt_irq;
        end
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        tb_valid = 0; tb_write = 0; tb_done = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input bit [1:0] a, input bit [RW-1:0] d);
        tb_valid = 1; tb_write = 1; tb_addr = a; tb_wdata = d;
        step();
        tb_valid = 0; tb_write = 0;
    endtask

    task automatic rd(input bit [1:0] a);
        tb_valid = 1; tb_write = 0; tb_addr = a;
        step();
        tb_valid = 0;
    endtask

    task automatic pulse(input bit [NB-1:0] p);
        tb_done = p;
        step();
        tb_done = '0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        #1;
        idle(3);
        rst_n = 1;
        idle(1);
        rd(0); rd(1); rd(2); rd(3); idle(1);

        // R2: pulses on edge buffers of both halves, then read back
        cur_req = "R2";
        pulse(64'h8000_0001_8000_0001);
        rd(0); rd(1); idle(1);
        pulse(64'h0123_4567_89AB_CDEF);
        rd(1); rd(0); idle(1);

        // R3: write-one clear, zeros leave flags alone
        cur_req = "R3";
        wr(0, 32'h0000_0000);
        rd(0);
        wr(0, 32'h8000_00FF);
        rd(0);
        wr(1, 32'hFFFF_0000);
        rd(1); idle(1);

        // R4: set and clear collide on one bit
        cur_req = "R4";
        tb_done = 64'h0000_0010_0000_0004;
        wr(0, 32'h0000_0004);
        tb_done = 64'h0000_0010_0000_0000;
        wr(1, 32'h0000_0010);
        tb_done = '0;
        rd(0); rd(1); idle(1);

        // R5: enable registers read back
        cur_req = "R5";
        wr(2, 32'hA5A5_5A5A); wr(3, 32'h0F0F_F0F0);
        rd(2); rd(3);
        wr(2, 32'h0); wr(3, 32'h0);
        rd(2); rd(3); idle(1);

        // R6: enable writes move irq while flags stay pending
        cur_req = "R6";
        wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
        pulse(64'h4000_0000_0000_0000);
        idle(2);
        wr(3, 32'h4000_0000);
        idle(2);
        wr(3, 32'h0);
        idle(2);
        wr(3, 32'h4000_0000);
        idle(1);
        wr(1, 32'h4000_0000);
        idle(2);

        // R7: write lockout under abort mode, transmit buffers only
        cur_req = "R7";
        tb_tx = 64'h0000_FFFF_0000_FFFF;
        pulse(64'h0001_0001_0001_0001);
        idle(1);
        tb_abort = 1;
        idle(2);
        wr(0, 32'h0000_0001);
        idle(1);
        tb_abort = 0;
        idle(1);

        // R8: back-to-back reads and a read colliding with a pulse
        cur_req = "R8";
        rd(0); rd(1); rd(2);
        tb_done = 64'h0000_0000_0000_0100;
        rd(0);
        tb_done = '0;
        rd(0); idle(2);

        // mixed random traffic across all requirements
        cur_req = "R2-R8 random";
        for (int i = 0; i < 400; i++) begin
            tb_done  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            tb_tx    = {$urandom, $urandom};
            tb_abort = $urandom_range(0, 1);
            tb_valid = ($urandom_range(0, 3) != 0);
            tb_write = $urandom_range(0, 1);
            tb_addr  = 2'($urandom_range(0, 3));
            tb_wdata = $urandom;
            step();
        end
        idle(2);

        // R1: reset in the middle of activity
        cur_req = "R1 mid-run";
        rst_n = 0;
        idle(2);
        rst_n = 1;
        rd(0); rd(2); idle(1);

        finish_run();
    end

endmodule